// File: doc/BRIEF.md
# Set-Associative Cache Victim Selector

This block keeps the replacement state of every set in a set-associative cache and names the way to evict when a miss must be placed. Each cycle the cache controller presents one lookup: the set index, whether the lookup hit, which way hit, and the valid bits of that set's ways. The block answers combinationally with `victim_way` for that set. On the clock edge it updates the set's state. A hit counts as a use of the hit way. A miss counts as a fill of `victim_way`.

A free slot is always used first: if any way of the set is invalid, the lowest-numbered invalid way is returned. Only when every way is occupied does the configured policy decide. Three policies are available through a parameter. The first is a binary tree of one-bit nodes that approximates least-recently-used order. The second is a per-set round-robin pointer. The third is a round-robin pointer that never picks the way used most recently in that set.

Top module: `way_victim_picker`

## Requirements
- R1: After reset, with every way valid, every set reports victim 0 in tree and round-robin modes, and victim 1 in skip mode, because the recorded most-recent way is cleared to 0.
- R2: When `way_valid` has any 0 bit, `victim_way` is the lowest index whose valid bit is 0, in every mode. A fill into such a way does not advance the round-robin pointer.
- R3: In tree mode, a lookup with `lookup_en` high (a hit on `hit_way`, or a fill of `victim_way`) sets each tree node on the path to that way so that it points to the other subtree. The touched way is therefore not the set's next victim.
- R4: In tree mode, with all ways valid, the victim is found by walking from the root: a node bit of 0 selects the lower-numbered half and 1 the upper half. The bits read form the way number, most significant first.
- R5: In round-robin mode, with all ways valid, the victim is the set's pointer. A miss that evicts advances the pointer by one, modulo the number of ways.
- R6: In round-robin mode, hits do not change the set's victim.
- R7: In skip mode, with all ways valid, the victim is the pointer unless the pointer equals the set's most recently used way, in which case it is the next way. After an eviction the pointer moves to the way after the victim.
- R8: Every lookup records the touched way (the hit way, or the filled way) as the set's most recently used way.
- R9: A lookup changes only the state of its own set. The victims of other sets are unaffected.
- R10: `victim_way` follows `lookup_set` and `way_valid` in the same cycle with no register delay. Updates made by a lookup are visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lookup_en | input | 1 | A lookup is presented this cycle and updates state at the edge |
| lookup_set | input | $clog2(SETS) | Set index of the lookup |
| lookup_hit | input | 1 | 1 when the lookup hit; 0 means the miss is filled into `victim_way` |
| hit_way | input | $clog2(WAYS) | Way that hit (used when `lookup_hit` is 1) |
| way_valid | input | WAYS | Valid bit of each way of the addressed set |
| victim_way | output | $clog2(WAYS) | Way chosen for a fill in the addressed set |

## Verification
On every cycle, the assertions check four things. An invalid way is never passed over. The tree never points back at the way it was just given. The round-robin pointer moves only on an eviction, and only to the way after the victim. In skip mode, an eviction never lands on the recorded most recent way. Other properties only the bench scenarios can show: the exact victim after long mixed hit and miss histories in each mode, the lowest-index choice among several free ways, that sets are independent, and the values left by reset. The bench computes these from its own model of the three policies.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  typedef enum logic [1:0] {
    POL_PLRU     = 2'd0,
    POL_FIFO     = 2'd1,
    POL_SKIP_MRU = 2'd2
  } policy_e;
endpackage

// File: rtl/vsel_rst_sync.sv
module vsel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/vsel_first_free.sv
module vsel_first_free #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid,
  output logic             any_free,
  output logic [WAY_W-1:0] free_way
);
  always_comb begin
    any_free = 1'b0;
    free_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        any_free = 1'b1;
        free_way = WAY_W'(i);
      end
    end
  end
endmodule

// File: rtl/vsel_plru.sv
module vsel_plru #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS),
  localparam int NODES = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set,
  output logic [WAY_W-1:0] victim,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way
);
  logic [NODES-1:0] tree_q [SETS];
  logic [NODES-1:0] tree_cur;
  logic [NODES-1:0] tree_d;

  assign tree_cur = tree_q[set];

  // Walk from the root: each node bit picks the half holding the victim
  always_comb begin
    int idx;
    idx    = 0;
    victim = '0;
    for (int l = 0; l < WAY_W; l++) begin
      victim[WAY_W-1-l] = tree_cur[idx];
      idx = 2 * idx + 1 + int'(tree_cur[idx]);
    end
  end

  // Point every node on the path to the touched way at the other subtree
  always_comb begin
    int node;
    tree_d = tree_cur;
    for (int l = 0; l < WAY_W; l++) begin
      node = (1 << l) - 1 + int'(touch_way >> (WAY_W - l));
      tree_d[node] = ~touch_way[WAY_W-1-l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch_en) begin
      tree_q[set] <= tree_d;
    end
  end

  // R3: the way just touched is not the next victim of the same set
  a_r3_points_away: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (set != $past(set)) || (victim != $past(touch_way)));
endmodule

// File: rtl/vsel_rr.sv
module vsel_rr #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  parameter bit SKIP = 1'b0,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set,
  output logic [WAY_W-1:0] victim,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  input  logic             advance
);
  logic [WAY_W-1:0] ptr_q [SETS];
  logic [WAY_W-1:0] mru_q [SETS];
  logic [WAY_W-1:0] ptr_cur;
  logic [WAY_W-1:0] ptr_d;

  assign ptr_cur = ptr_q[set];

  generate
    if (SKIP) begin : g_skip
      assign victim = (ptr_cur == mru_q[set]) ? ptr_cur + WAY_W'(1) : ptr_cur;
      // R7: an eviction never lands on the most recently used way
      a_r7_not_mru: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> victim != mru_q[set]);
    end else begin : g_plain
      assign victim = ptr_cur;
    end
  endgenerate

  assign ptr_d = victim + WAY_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        ptr_q[s] <= '0;
        mru_q[s] <= '0;
      end
    end else begin
      if (advance)  ptr_q[set] <= ptr_d;
      if (touch_en) mru_q[set] <= touch_way;
    end
  end

  // R5: an eviction moves the pointer to the way after the victim
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> ptr_q[$past(set)] == WAY_W'($past(victim) + WAY_W'(1)));
  // R6: lookups that do not evict leave the pointer alone
  a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_en && !advance) |=> ptr_q[$past(set)] == $past(ptr_cur));
  // R8: the touched way becomes the recorded most recent way
  a_r8_mru_record: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> mru_q[$past(set)] == $past(touch_way));
endmodule

// File: rtl/way_victim_picker.sv
module way_victim_picker
  import vsel_pkg::*;
#(
  parameter int      WAYS   = 4,
  parameter int      SETS   = 16,
  parameter policy_e POLICY = POL_PLRU,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lookup_en,
  input  logic [SET_W-1:0] lookup_set,
  input  logic             lookup_hit,
  input  logic [WAY_W-1:0] hit_way,
  input  logic [WAYS-1:0]  way_valid,
  output logic [WAY_W-1:0] victim_way
);
  logic             rst_q_n;
  logic             any_free;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] policy_way;
  logic [WAY_W-1:0] touch_way;
  logic             evict;

  vsel_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  vsel_first_free #(.WAYS(WAYS)) i_first_free (
    .valid    (way_valid),
    .any_free (any_free),
    .free_way (free_way)
  );

  assign victim_way = any_free ? free_way : policy_way;
  assign touch_way  = lookup_hit ? hit_way : victim_way;
  assign evict      = lookup_en && !lookup_hit && !any_free;

  generate
    if (POLICY == POL_PLRU) begin : g_plru
      vsel_plru #(.WAYS(WAYS), .SETS(SETS)) i_plru (
        .clk       (clk),
        .rst_n     (rst_q_n),
        .set       (lookup_set),
        .victim    (policy_way),
        .touch_en  (lookup_en),
        .touch_way (touch_way)
      );
    end else begin : g_rr
      vsel_rr #(.WAYS(WAYS), .SETS(SETS), .SKIP(POLICY == POL_SKIP_MRU)) i_rr (
        .clk       (clk),
        .rst_n     (rst_q_n),
        .set       (lookup_set),
        .victim    (policy_way),
        .touch_en  (lookup_en),
        .touch_way (touch_way),
        .advance   (evict)
      );
    end
  endgenerate

  // R2: a free way is never passed over for an occupied one
  a_r2_free_first: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(&way_valid) |-> !way_valid[victim_way]);
endmodule

// File: tb/test_way_victim_picker.sv
`timescale 1ns/100ps
module test_way_victim_picker;
  import vsel_pkg::*;
  localparam int WAYS = 4;
  localparam int SETS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lookup_en = 1'b0;
  logic [2:0] lookup_set = '0;
  logic       lookup_hit = 1'b0;
  logic [1:0] hit_way = '0;
  logic [3:0] way_valid = '1;
  logic [1:0] v_plru, v_fifo, v_skip;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  way_victim_picker #(.WAYS(WAYS), .SETS(SETS), .POLICY(POL_PLRU)) i_way_victim_picker (
    .clk(clk), .rst_n(rst_n), .lookup_en(lookup_en), .lookup_set(lookup_set),
    .lookup_hit(lookup_hit), .hit_way(hit_way), .way_valid(way_valid), .victim_way(v_plru));
  way_victim_picker #(.WAYS(WAYS), .SETS(SETS), .POLICY(POL_FIFO)) i_way_victim_picker_fifo (
    .clk(clk), .rst_n(rst_n), .lookup_en(lookup_en), .lookup_set(lookup_set),
    .lookup_hit(lookup_hit), .hit_way(hit_way), .way_valid(way_valid), .victim_way(v_fifo));
  way_victim_picker #(.WAYS(WAYS), .SETS(SETS), .POLICY(POL_SKIP_MRU)) i_way_victim_picker_skip (
    .clk(clk), .rst_n(rst_n), .lookup_en(lookup_en), .lookup_set(lookup_set),
    .lookup_hit(lookup_hit), .hit_way(hit_way), .way_valid(way_valid), .victim_way(v_skip));

  // Bench model of the replacement state
  bit [2:0] m_tree [SETS];
  bit [1:0] m_pf   [SETS];
  bit [1:0] m_ps   [SETS];
  bit [1:0] m_ms   [SETS];

  function automatic int free_of(bit [3:0] v);
    for (int i = 0; i < WAYS; i++) if (!v[i]) return i;
    return -1;
  endfunction

  function automatic int tree_victim(int s);
    int idx = 0;
    int w = 0;
    for (int l = 0; l < 2; l++) begin
      w = w * 2 + int'(m_tree[s][idx]);
      idx = 2 * idx + 1 + int'(m_tree[s][idx]);
    end
    return w;
  endfunction

  function automatic void tree_touch(int s, int w);
    m_tree[s][0] = ~w[1];
    m_tree[s][1 + w / 2] = ~w[0];
  endfunction

  function automatic int skip_victim(int s);
    return (m_ps[s] == m_ms[s]) ? int'(2'(m_ps[s] + 2'd1)) : int'(m_ps[s]);
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int exp_p(int s, bit [3:0] v);
    int f = free_of(v);
    return (f >= 0) ? f : tree_victim(s);
  endfunction
  function automatic int exp_f(int s, bit [3:0] v);
    int f = free_of(v);
    return (f >= 0) ? f : int'(m_pf[s]);
  endfunction
  function automatic int exp_s(int s, bit [3:0] v);
    int f = free_of(v);
    return (f >= 0) ? f : skip_victim(s);
  endfunction

  task automatic check_all(string tag, int s, bit [3:0] v);
    bit fr = free_of(v) >= 0;
    chk(tag != "" ? tag : (fr ? "R2 tree" : "R4 tree"), int'(v_plru), exp_p(s, v));
    chk(tag != "" ? tag : (fr ? "R2 fifo" : "R5 fifo"), int'(v_fifo), exp_f(s, v));
    chk(tag != "" ? tag : (fr ? "R2 skip" : "R7 skip"), int'(v_skip), exp_s(s, v));
  endtask

  // Present set and valid bits without a lookup, then check
  task automatic peek(int s, bit [3:0] v, string tag);
    @(negedge clk);
    lookup_en = 1'b0; lookup_set = 3'(s); way_valid = v;
    #1;
    check_all(tag, s, v);
  endtask

  task automatic op(int s, bit hit, int w, bit [3:0] v, string tag);
    int ep, ef, es;
    bit evict;
    @(negedge clk);
    lookup_en = 1'b1; lookup_set = 3'(s); lookup_hit = hit; hit_way = 2'(w); way_valid = v;
    #1;
    check_all(tag, s, v);
    ep = exp_p(s, v); ef = exp_f(s, v); es = exp_s(s, v);
    evict = !hit && (free_of(v) < 0);
    @(posedge clk);
    #1;
    lookup_en = 1'b0;
    tree_touch(s, hit ? w : ep);
    if (evict) begin
      m_pf[s] = 2'(ef + 1);
      m_ps[s] = 2'(es + 1);
    end
    m_ms[s] = 2'(hit ? w : es);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int s = 0; s < SETS; s++) begin
      m_tree[s] = '0; m_pf[s] = '0; m_ps[s] = '0; m_ms[s] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset values
    peek(0, 4'hF, "R1");
    peek(7, 4'hF, "R1");
    // R2: lowest free way among several
    peek(1, 4'b0101, "R2");
    peek(1, 4'b0111, "R2");
    op(1, 1'b0, 0, 4'b1001, "R2");
    peek(1, 4'hF, "R2");
    // R3: touched way not next victim in the tree
    op(3, 1'b1, 0, 4'hF, "R3");
    peek(3, 4'hF, "R3");
    op(3, 1'b1, 2, 4'hF, "R3");
    peek(3, 4'hF, "R3");
    // R6: hits leave the round-robin victim unchanged
    op(5, 1'b1, 2, 4'hF, "R6");
    op(5, 1'b1, 0, 4'hF, "R6");
    peek(5, 4'hF, "R6");
    // R8: most recent way follows hits in skip mode
    op(6, 1'b1, 1, 4'hF, "R8");
    peek(6, 4'hF, "R8");
    op(6, 1'b1, 0, 4'hF, "R8");
    peek(6, 4'hF, "R8");
    // R5 / R7: back-to-back evictions
    for (int k = 0; k < 6; k++) op(2, 1'b0, 0, 4'hF, "");
    // R9: other sets untouched
    peek(4, 4'hF, "R9");
    peek(7, 4'hF, "R9");
    // R10: output follows the set index within the cycle
    @(negedge clk);
    lookup_set = 3'd2; way_valid = 4'hF;
    #1 check_all("R10", 2, 4'hF);
    lookup_set = 3'd4;
    #1 check_all("R10", 4, 4'hF);

    // Constrained random mix
    for (int k = 0; k < 3000; k++) begin
      int s = $urandom_range(0, SETS - 1);
      bit hit = $urandom_range(0, 2) != 0;
      int w = $urandom_range(0, WAYS - 1);
      bit [3:0] v = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 15)) : 4'hF;
      if (hit && !v[w]) v[w] = 1'b1;
      op(s, hit, w, v, "");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule